// File: doc/BRIEF.md
# UART Interrupt Cause Identification

This block turns the interrupt sources of a 16550-style serial port into one interrupt line and a readable identification byte. It takes four sources: line-status errors, received data (threshold reached or character timeout), transmit holding register empty, and modem line changes. A four-bit enable register masks each source. The identification byte reports only the most urgent enabled cause.

The block also applies the read side effects that acknowledge each source. A line-status read drops the line-error condition. A modem-status read clears the latched change bits, which the block holds and outputs. An identification read drops the transmit-empty cause, but only when that read reported it. Received-data causes are levels owned by the receive path, so reading the data clears them there.

The transmit-empty source is tracked by a three-state machine. In `TX_BUSY` the holding register is full. In `TX_PEND` it is empty and the cause is pending. In `TX_QUIET` it is empty and the cause has been acknowledged. The transitions are:
- `TX_BUSY`→`TX_PEND` when the register empties.
- `TX_PEND`→`TX_QUIET` on an identification read that reported transmit-empty.
- `TX_PEND`/`TX_QUIET`→`TX_BUSY` when the register is written.
- `TX_QUIET`→`TX_PEND` when its enable bit rises.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01 with FIFO mode off, the modem change bits read 0, and the interrupt output is low while auxiliary output 2 is low.
- R2: Enable bit 0 gates received data and timeout, bit 1 gates transmit-empty, bit 2 gates line status and bit 3 gates modem change. A source whose enable bit is 0 never affects the identification byte.
- R3: The identification code in bits [3:0] is:
  - 0x6 for line status.
  - 0x4 for received data.
  - 0xC for character timeout.
  - 0x2 for transmit-empty.
  - 0x0 for modem change.
  - 0x1 when nothing is pending.
- R4: Priority from highest to lowest is line status, then receive (timeout reported in place of data when both are present), then transmit-empty, then modem change.
- R5: Bit 0 reads 0 exactly when an enabled cause is pending. Bits [5:4] always read 0.
- R6: Bits [7:6] read 11 while FIFO mode is enabled and 00 otherwise.
- R7: A line-status error event latches until a line-status read. An event arriving in the same cycle as that read stays latched.
- R8: An identification read that reports transmit-empty clears that cause. An identification read that reports any other cause leaves a pending transmit-empty in place.
- R9: Transmit-empty becomes pending again when the holding register goes full and then empty, or when its enable bit goes from 0 to 1 while the register is empty.
- R10: Modem change bits accumulate (OR) until a modem-status read, which clears them. Changes arriving in the read cycle are kept.
- R11: The interrupt output is the OR of "an enabled cause is pending" and auxiliary output 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_i | input | 4 | Interrupt enable register |
| fifo_en_i | input | 1 | FIFO mode enabled |
| out2_i | input | 1 | Modem-control auxiliary output 2 |
| line_evt_i | input | 1 | Pulse: line error or break detected |
| rx_avail_i | input | 1 | Level: received data available / threshold reached |
| rx_tmo_i | input | 1 | Level: character timeout |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| modem_chg_i | input | 4 | Pulses: change seen on each modem input |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| msr_rd_i | input | 1 | Modem-status register read strobe |
| irq_o | output | 1 | Interrupt output |
| iir_o | output | 8 | Identification byte |
| modem_delta_o | output | 4 | Latched modem change bits |

## Verification
The assertions take two things for granted about the inputs:
- Read strobes are single-cycle pulses sampled on the clock edge.
- The transmit-empty flag changes only on clock edges, so an identification read sees the same cause that the identification byte shows in that cycle.

The stimulus drives every input one time unit after a rising edge and holds each strobe for exactly one cycle. It sweeps all enable masks, all source combinations and both FIFO settings. Each source condition is set up through its own event pulse or its own read strobe, never by reaching inside the block.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    localparam int IER_W = 4;
    localparam int MDM_W = 4;

    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    localparam logic [3:0] CODE_LINE  = 4'h6;
    localparam logic [3:0] CODE_RXDAT = 4'h4;
    localparam logic [3:0] CODE_TMO   = 4'hC;
    localparam logic [3:0] CODE_THRE  = 4'h2;
    localparam logic [3:0] CODE_MODEM = 4'h0;
    localparam logic [3:0] CODE_NONE  = 4'h1;

    typedef enum logic [1:0] {
        TX_BUSY  = 2'd0,
        TX_PEND  = 2'd1,
        TX_QUIET = 2'd2
    } tx_state_e;

endpackage

// File: rtl/uart_iid_sticky.sv
module uart_iid_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flag_o
);

    logic [W-1:0] flag_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (clr_i)
                flag_q[g] <= set_i[g];
            else
                flag_q[g] <= flag_q[g] | set_i[g];
        end
    end

    assign flag_o = flag_q;

    // R7 / R10: a read clears, but an event in the read cycle survives
    a_r7_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flag_o == $past(set_i)));

    // R10: without a read, latched bits never drop
    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

endmodule

// File: rtl/uart_iid_txtrack.sv
module uart_iid_txtrack
    import uart_iid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty_i,
    input  logic thr_en_i,
    input  logic ack_i,
    output logic pend_o
);

    tx_state_e state_q, state_d;
    logic      en_q;
    logic      en_rise;

    assign en_rise = thr_en_i & ~en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_BUSY;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= thr_en_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_BUSY: begin
                if (thr_empty_i) state_d = TX_PEND;
            end
            TX_PEND: begin
                if (!thr_empty_i)  state_d = TX_BUSY;
                else if (ack_i)    state_d = TX_QUIET;
            end
            TX_QUIET: begin
                if (!thr_empty_i)  state_d = TX_BUSY;
                else if (en_rise)  state_d = TX_PEND;
            end
            default: state_d = TX_BUSY;
        endcase
    end

    always_comb begin
        pend_o = (state_q == TX_PEND);
    end

    // R9: a full holding register never leaves the cause pending
    a_r9_full_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_empty_i |=> !pend_o);

    // R8: acknowledging a pending cause drops it
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_o) |=> !pend_o);

    // R9: enable rising while empty re-arms
    a_r9_enable_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(thr_en_i) && thr_empty_i && !ack_i) |=> pend_o);

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  logic [IER_W-1:0] ier_i,
    input  logic             line_p_i,
    input  logic             rx_avail_i,
    input  logic             rx_tmo_i,
    input  logic             thre_p_i,
    input  logic             modem_p_i,
    input  logic             fifo_en_i,
    output logic [7:0]       id_o,
    output logic             any_o
);

    logic [3:0] code;

    always_comb begin
        if (ier_i[EN_LINE] && line_p_i)
            code = CODE_LINE;
        else if (ier_i[EN_RX] && rx_tmo_i)
            code = CODE_TMO;
        else if (ier_i[EN_RX] && rx_avail_i)
            code = CODE_RXDAT;
        else if (ier_i[EN_THRE] && thre_p_i)
            code = CODE_THRE;
        else if (ier_i[EN_MODEM] && modem_p_i)
            code = CODE_MODEM;
        else
            code = CODE_NONE;
    end

    always_comb begin
        any_o = ~code[0];
        id_o  = {{2{fifo_en_i}}, 2'b00, code};
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IER_W-1:0] ier_i,
    input  logic             fifo_en_i,
    input  logic             out2_i,
    input  logic             line_evt_i,
    input  logic             rx_avail_i,
    input  logic             rx_tmo_i,
    input  logic             thr_empty_i,
    input  logic [MDM_W-1:0] modem_chg_i,
    input  logic             iir_rd_i,
    input  logic             lsr_rd_i,
    input  logic             msr_rd_i,
    output logic             irq_o,
    output logic [7:0]       iir_o,
    output logic [MDM_W-1:0] modem_delta_o
);

    logic line_flag;
    logic thre_pend;
    logic thre_ack;
    logic any_pend;

    uart_iid_sticky #(.W(1)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (line_evt_i),
        .clr_i  (lsr_rd_i),
        .flag_o (line_flag)
    );

    uart_iid_sticky #(.W(MDM_W)) u_modem (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (modem_chg_i),
        .clr_i  (msr_rd_i),
        .flag_o (modem_delta_o)
    );

    assign thre_ack = iir_rd_i && (iir_o[3:0] == CODE_THRE);

    uart_iid_txtrack u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_empty_i (thr_empty_i),
        .thr_en_i    (ier_i[EN_THRE]),
        .ack_i       (thre_ack),
        .pend_o      (thre_pend)
    );

    uart_iid_prio u_prio (
        .ier_i      (ier_i),
        .line_p_i   (line_flag),
        .rx_avail_i (rx_avail_i),
        .rx_tmo_i   (rx_tmo_i),
        .thre_p_i   (thre_pend),
        .modem_p_i  (|modem_delta_o),
        .fifo_en_i  (fifo_en_i),
        .id_o       (iir_o),
        .any_o      (any_pend)
    );

    assign irq_o = any_pend | out2_i;

    // R4: a latched, enabled line condition always wins
    a_r4_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i[EN_LINE] && line_flag) |-> (iir_o[3:0] == CODE_LINE));

    // R11: a reported cause always drives the interrupt line
    a_r11_irq_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !iir_o[0] |-> irq_o);

    // R8: after reporting and reading transmit-empty, it is not reported next cycle
    a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd_i && iir_o[3:0] == CODE_THRE) |=> (iir_o[3:0] != CODE_THRE));

    // R5: reserved bits stay low
    a_r5_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[5:4] == 2'b00);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ier = '0;
    logic       fifo_en = 1'b0, out2 = 1'b0, line_evt = 1'b0;
    logic       rx_avail = 1'b0, rx_tmo = 1'b0, thr_empty = 1'b0;
    logic [3:0] modem_chg = '0;
    logic       iir_rd = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0;
    logic       irq;
    logic [7:0] iir;
    logic [3:0] mdelta;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
        .out2_i(out2), .line_evt_i(line_evt), .rx_avail_i(rx_avail),
        .rx_tmo_i(rx_tmo), .thr_empty_i(thr_empty), .modem_chg_i(modem_chg),
        .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd),
        .irq_o(irq), .iir_o(iir), .modem_delta_o(mdelta)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_iir(input logic [3:0] en, input logic ls,
        input logic av, input logic to, input logic th, input logic ms, input logic ff);
        logic [3:0] c;
        if (en[2] && ls)                c = 4'h6;
        else if (en[0] && to)           c = 4'hC;
        else if (en[0] && av)           c = 4'h4;
        else if (en[1] && th)           c = 4'h2;
        else if (en[3] && ms)           c = 4'h0;
        else                            c = 4'h1;
        return {ff, ff, 2'b00, c};
    endfunction

    initial begin
        // R1: reset state
        #1;
        chk("R1 iir", iir, 8'h01);
        chk("R1 delta", {4'h0, mdelta}, 8'h00);
        chk("R1 irq", {7'h0, irq}, 8'h00);
        step();
        rst_n = 1'b1;
        step();
        chk("R1 iir after release", iir, 8'h01);

        // R8: read reporting transmit-empty clears it
        ier = 4'b0010;
        thr_empty = 1'b1;
        step();
        chk("R3 thre code", iir, 8'h02);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R8 cleared by id read", iir, 8'h01);

        // R9: enable 0->1 while empty re-arms
        ier = 4'b0000; step();
        ier = 4'b0010; step();
        chk("R9 enable rise rearm", iir, 8'h02);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R8 cleared again", iir, 8'h01);
        // R9: full then empty re-arms
        thr_empty = 1'b0; step();
        chk("R9 full not pending", iir, 8'h01);
        thr_empty = 1'b1; step();
        chk("R9 empty again rearm", iir, 8'h02);

        // R8: read reporting line status leaves transmit-empty pending
        ier = 4'b0110;
        line_evt = 1'b1; step(); line_evt = 1'b0;
        chk("R4 line over thre", iir, 8'h06);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R8 other cause read keeps line", iir, 8'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R8 thre survives other read", iir, 8'h02);

        // R7: event in the read cycle stays latched
        lsr_rd = 1'b1; line_evt = 1'b1; step(); lsr_rd = 1'b0; line_evt = 1'b0;
        chk("R7 same-cycle event kept", iir, 8'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R7 read clears", iir, 8'h02);

        // R10: accumulation and same-cycle keep
        modem_chg = 4'b0001; step();
        modem_chg = 4'b1000; step(); modem_chg = 4'b0000;
        chk("R10 accumulate", {4'h0, mdelta}, 8'h09);
        msr_rd = 1'b1; modem_chg = 4'b0100; step();
        msr_rd = 1'b0; modem_chg = 4'b0000;
        chk("R10 same-cycle kept", {4'h0, mdelta}, 8'h04);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk("R10 read clears", {4'h0, mdelta}, 8'h00);

        // R11: auxiliary output alone drives irq
        ier = 4'b0000; out2 = 1'b1; #1;
        chk("R11 out2 only", {7'h0, irq}, 8'h01);
        out2 = 1'b0; #1;
        chk("R11 idle low", {7'h0, irq}, 8'h00);

        // R2 R3 R4 R5 R6 R11: sweep all masks, sources and FIFO mode
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 16; e++) begin
                for (int s = 0; s < 32; s++) begin
                    logic ls, av, to, th, ms;
                    ls = s[0]; av = s[1]; to = s[2]; th = s[3]; ms = s[4];
                    ier = e[3:0];
                    fifo_en = f[0];
                    out2 = s[0] ^ e[0] ^ f[0] ^ s[3];
                    rx_avail = av;
                    rx_tmo = to;
                    if (ls) line_evt = 1'b1; else lsr_rd = 1'b1;
                    if (ms) modem_chg = 4'b0101; else msr_rd = 1'b1;
                    thr_empty = 1'b0;
                    step();
                    line_evt = 1'b0; lsr_rd = 1'b0;
                    modem_chg = 4'b0000; msr_rd = 1'b0;
                    thr_empty = th;
                    step();
                    begin
                        logic [7:0] ex;
                        ex = exp_iir(e[3:0], ls, av, to, th, ms, f[0]);
                        chk("R2 R3 R4 R5 R6 sweep iir", iir, ex);
                        chk("R11 sweep irq", {7'h0, irq}, {7'h0, (~ex[0]) | out2});
                        chk("R10 sweep delta", {4'h0, mdelta}, ms ? 8'h05 : 8'h00);
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule